// File: doc/BRIEF.md
# I2C Target Receiver with Receive Queue and Clock Stretching

This block is the receive half of an I2C target. It watches already filtered SCL and SDA levels and finds start and stop conditions. It shifts in the first byte of a transfer and decides whether to acknowledge it. It then collects the data bytes that follow into a small first-in first-out queue. The block answers each byte with an ACK or a NACK, as software chooses. When software has to act, the block holds SCL low, which stretches the bus clock. SCL and SDA are driven only through pull-down enables, as open-drain outputs.

Software uses a plain register-style port. The port shows the oldest queued byte and pops it. It also clears the interrupt flag and the two bus-condition flags, and it sets the acknowledge level, the stretch point and the queue threshold.

With the queue disabled, the block stops the bus once for every byte. The stop comes either before or after the acknowledge slot. With the queue enabled, the bus runs freely. It stops only on a NACK or when the queue is full, and it raises a ready flag once a chosen number of bytes are waiting.

Top module: `i2c_target_rx`

## Requirements
- R1: After reset, both pull-down outputs are 0. The interrupt, reserved, stop, repeated-start, ready and receive-interrupt outputs are 0, and the queue level is 0.
- R2: The first byte after a start carries the address in bits 7..1, MSB first. The R/W bit is bit 0, and 0 means write. The byte matches when it is a write and the 7-bit address equals `cfg_own_addr` at every bit where `cfg_addr_mask` is 1. On a match, the block pulls SDA low during the 9th clock. After the 9th falling SCL edge it sets the interrupt flag and holds SCL low.
- R3: A first byte whose upper four bits are 0000 or 1111 is treated as reserved, whatever its R/W bit. It is acknowledged and interrupted like a match, and `reserved_o` reads 1. A first byte that neither matches nor is reserved gets no ACK and no interrupt. It also leaves the stop flag untouched at the following stop.
- R4: Data bytes are taken MSB first on rising SCL edges and are queued in arrival order. `rx_data_o` shows the oldest byte, `host_pop` removes it, and `rx_level_o` counts the queued bytes, up to 16.
- R5: With the queue disabled and `cfg_wait_sel`=0, the block sets the interrupt flag and holds SCL low at the 8th falling edge of every data byte. This is before the acknowledge slot, and no hold follows the 9th clock.
- R6: With the queue disabled and `cfg_wait_sel`=1, there is no hold after the 8th bit. The block sets the interrupt flag and holds SCL low after the 9th falling edge of every data byte.
- R7: The acknowledge level for a data byte is `cfg_ack_en` at the 8th falling SCL edge, where 1 means ACK (SDA low) and 0 means NACK. If a hold is active at that point, the value present when the hold ends is used.
- R8: With the queue enabled, acknowledged bytes raise no interrupt and cause no hold while the queue has room. A NACKed byte sets the interrupt flag and holds SCL low after its 9th clock.
- R9: With the queue enabled, if the queue is full after a byte's 9th clock, SCL is held low without setting the interrupt flag. One `host_pop` releases the hold.
- R10: A stop or repeated start while the block is addressed sets `stop_flag_o` or `rstart_flag_o`. Neither sets the interrupt flag or holds SCL, and `host_cond_clr` clears both flags.
- R11: `rx_ready_o` goes to 1 when a queued byte brings the level equal to a nonzero `cfg_rx_thresh`. It returns to 0 when the level falls below the threshold, and it stays 0 while the threshold is 0. `rx_irq_o` is `rx_ready_o` gated by `cfg_rx_ie`.
- R12: `host_int_clr` clears the interrupt flag and ends an interrupt hold. With the queue enabled and full, the hold continues as a full-queue hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Filtered SCL level |
| sda_i | input | 1 | Filtered SDA level |
| scl_pd_o | output | 1 | 1 pulls SCL low (stretch) |
| sda_pd_o | output | 1 | 1 pulls SDA low (acknowledge) |
| cfg_own_addr | input | 7 | Own 7-bit address |
| cfg_addr_mask | input | 7 | 1 = address bit must match |
| cfg_fifo_en | input | 1 | 1 = queued mode |
| cfg_wait_sel | input | 1 | Stretch point with queue off: 0 after bit 8, 1 after ACK |
| cfg_ack_en | input | 1 | 1 = acknowledge data bytes |
| cfg_rx_thresh | input | 5 | Byte count for the ready flag, 0 = off |
| cfg_rx_ie | input | 1 | Receive interrupt enable |
| host_pop | input | 1 | Pop the oldest queued byte |
| host_int_clr | input | 1 | Clear the interrupt flag |
| host_cond_clr | input | 1 | Clear the stop and repeated-start flags |
| rx_data_o | output | 8 | Oldest queued byte |
| rx_level_o | output | 5 | Number of queued bytes |
| int_flag_o | output | 1 | Interrupt flag |
| reserved_o | output | 1 | Last accepted first byte was reserved |
| stop_flag_o | output | 1 | Stop seen while addressed |
| rstart_flag_o | output | 1 | Repeated start seen while addressed |
| rx_ready_o | output | 1 | Threshold reached |
| rx_irq_o | output | 1 | Receive interrupt |

## Verification
Address decoding is driven from a table of first bytes:
- exact matches;
- a byte with the R/W bit set;
- a one-bit mismatch, once with that bit masked off and once with it compared;
- both reserved nibbles;
- a plain miss.

These cases separate a mask applied in the wrong sense and a read accepted as a write. They also show whether the reserved check is taken from the wrong bits. Each mode then receives its own byte stream:
- Queue off, stretch after bit 8: the acknowledge level is changed during the hold, which shows whether it is sampled at the edge or at release.
- Queue off, stretch after the acknowledge slot.
- Queue on: sixteen bytes in a row fill the queue to full, then a NACKed byte follows. Together they separate a full-queue hold from an interrupt hold.
A stop is compared against a repeated start, and the threshold is tried at 3, 1 and 0. Draining the queue in order exposes pointer and order errors.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_AACK,
        PH_DATA,
        PH_DACK
    } rx_phase_e;

    typedef enum logic [1:0] {
        HOLD_NONE,
        HOLD_INT,
        HOLD_FULL
    } hold_e;

    typedef struct packed {
        rx_phase_e          phase;
        logic [3:0]         bitcnt;
        logic [BYTE_W-1:0]  shreg;
        hold_e              hold;
        logic               sda_pd;
        logic               nack;
        logic               intf;
        logic               addressed;
        logic               reserved;
        logic               stop_f;
        logic               rstart_f;
    } ctrl_regs_t;

endpackage

// File: rtl/i2c_target_rx_cond.sv
module i2c_target_rx_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } line_regs_t;

    line_regs_t d, q;

    always_comb begin
        d     = q;
        d.scl = scl_i;
        d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign rise_o  = scl_i & ~q.scl;
    assign fall_o  = ~scl_i & q.scl;
    assign start_o = scl_i & q.scl & q.sda & ~sda_i;
    assign stop_o  = scl_i & q.scl & ~q.sda & sda_i;

endmodule

// File: rtl/i2c_target_rx_fifo.sv
module i2c_target_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [W-1:0]     push_data_i,
    input  logic             pop_i,
    input  logic [LVL_W-1:0] thresh_i,
    output logic [W-1:0]     head_o,
    output logic [LVL_W-1:0] level_o,
    output logic             full_o,
    output logic             ready_o
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [LVL_W-1:0]        level;
        logic                    rdy;
    } fifo_regs_t;

    fifo_regs_t d, q;
    logic do_push, do_pop;

    always_comb begin
        d       = q;
        do_push = push_i && (q.level != LVL_W'(DEPTH));
        do_pop  = pop_i && (q.level != '0);
        if (do_push) begin
            d.mem[q.wp] = push_data_i;
            d.wp = (q.wp == PTR_W'(DEPTH - 1)) ? '0 : q.wp + PTR_W'(1);
        end
        if (do_pop) begin
            d.rp = (q.rp == PTR_W'(DEPTH - 1)) ? '0 : q.rp + PTR_W'(1);
        end
        d.level = q.level + LVL_W'(do_push) - LVL_W'(do_pop);
        if (do_push && (thresh_i != '0) && (d.level == thresh_i)) begin
            d.rdy = 1'b1;
        end
        if ((thresh_i == '0) || (d.level < thresh_i)) begin
            d.rdy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign head_o  = q.mem[q.rp];
    assign level_o = q.level;
    assign full_o  = (q.level == LVL_W'(DEPTH));
    assign ready_o = q.rdy;

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (q.level != LVL_W'(DEPTH)));

    // R4
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.level <= LVL_W'(DEPTH));

    // R11
    ready_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.rdy |-> (($past(thresh_i) != '0) && (q.level >= $past(thresh_i))));

endmodule

// File: rtl/i2c_target_rx_ctrl.sv
module i2c_target_rx_ctrl
    import i2c_srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [ADDR_W-1:0] cfg_own_addr,
    input  logic [ADDR_W-1:0] cfg_addr_mask,
    input  logic              cfg_fifo_en,
    input  logic              cfg_wait_sel,
    input  logic              cfg_ack_en,
    input  logic              fifo_full_i,
    input  logic              host_int_clr,
    input  logic              host_cond_clr,
    output logic              push_o,
    output logic [BYTE_W-1:0] push_data_o,
    output logic              scl_pd_o,
    output logic              sda_pd_o,
    output logic              int_o,
    output logic              reserved_o,
    output logic              stop_o,
    output logic              rstart_o
);

    ctrl_regs_t d, q;
    logic hit, rsv;

    always_comb begin
        d      = q;
        push_o = 1'b0;
        hit = ((((q.shreg[BYTE_W-1:1] ^ cfg_own_addr) & cfg_addr_mask) == '0)
               && !q.shreg[0]);
        rsv = (q.shreg[7:4] == 4'h0) || (q.shreg[7:4] == 4'hF);

        if (host_cond_clr) begin
            d.stop_f   = 1'b0;
            d.rstart_f = 1'b0;
        end
        if (host_int_clr) begin
            d.intf = 1'b0;
            if (q.hold == HOLD_INT) begin
                d.hold = (cfg_fifo_en && fifo_full_i) ? HOLD_FULL : HOLD_NONE;
            end
        end
        if ((q.hold == HOLD_FULL) && !fifo_full_i) begin
            d.hold = HOLD_NONE;
        end

        if (start_i) begin
            if (q.addressed) d.rstart_f = 1'b1;
            d.phase     = PH_ADDR;
            d.bitcnt    = '0;
            d.addressed = 1'b0;
            d.hold      = HOLD_NONE;
            d.sda_pd    = 1'b0;
        end else if (stop_i) begin
            if (q.addressed) d.stop_f = 1'b1;
            d.phase     = PH_IDLE;
            d.addressed = 1'b0;
            d.hold      = HOLD_NONE;
            d.sda_pd    = 1'b0;
        end else begin
            unique case (q.phase)
                PH_ADDR: begin
                    if (rise_i && (q.bitcnt < 4'd8)) begin
                        d.shreg  = {q.shreg[BYTE_W-2:0], sda_i};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (fall_i && (q.bitcnt == 4'd8)) begin
                        if (hit || rsv) begin
                            d.sda_pd   = 1'b1;
                            d.reserved = rsv;
                            d.phase    = PH_AACK;
                        end else begin
                            d.phase = PH_IDLE;
                        end
                    end
                end
                PH_AACK: begin
                    if (fall_i) begin
                        d.sda_pd    = 1'b0;
                        d.intf      = 1'b1;
                        d.hold      = HOLD_INT;
                        d.addressed = 1'b1;
                        d.bitcnt    = '0;
                        d.phase     = PH_DATA;
                    end
                end
                PH_DATA: begin
                    if (rise_i && (q.bitcnt < 4'd8)) begin
                        d.shreg  = {q.shreg[BYTE_W-2:0], sda_i};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (fall_i && (q.bitcnt == 4'd8)) begin
                        push_o   = !fifo_full_i;
                        d.sda_pd = cfg_ack_en;
                        d.nack   = !cfg_ack_en;
                        if (!cfg_fifo_en && !cfg_wait_sel) begin
                            d.intf = 1'b1;
                            d.hold = HOLD_INT;
                        end
                        d.phase = PH_DACK;
                    end
                end
                PH_DACK: begin
                    if (q.hold != HOLD_NONE) begin
                        d.sda_pd = cfg_ack_en;
                        d.nack   = !cfg_ack_en;
                    end
                    if (fall_i) begin
                        d.sda_pd = 1'b0;
                        d.bitcnt = '0;
                        d.phase  = PH_DATA;
                        if (cfg_fifo_en) begin
                            if (q.nack) begin
                                d.intf = 1'b1;
                                d.hold = HOLD_INT;
                            end else if (fifo_full_i) begin
                                d.hold = HOLD_FULL;
                            end
                        end else if (cfg_wait_sel) begin
                            d.intf = 1'b1;
                            d.hold = HOLD_INT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign push_data_o = q.shreg;
    assign scl_pd_o    = (q.hold != HOLD_NONE);
    assign sda_pd_o    = q.sda_pd;
    assign int_o       = q.intf;
    assign reserved_o  = q.reserved;
    assign stop_o      = q.stop_f;
    assign rstart_o    = q.rstart_f;

    // R5
    hold_at_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.hold != HOLD_NONE) |-> !$past(scl_i));

    // R7
    sda_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.sda_pd) |-> !$past(scl_i));

    // R7
    ack_slot_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.sda_pd |-> ((q.phase == PH_AACK) || (q.phase == PH_DACK)));

    // R10
    cond_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q.stop_f) || $rose(q.rstart_f)) |-> !$rose(q.intf));

endmodule

// File: rtl/i2c_target_rx.sv
module i2c_target_rx
    import i2c_srx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_pd_o,
    output logic              sda_pd_o,
    input  logic [ADDR_W-1:0] cfg_own_addr,
    input  logic [ADDR_W-1:0] cfg_addr_mask,
    input  logic              cfg_fifo_en,
    input  logic              cfg_wait_sel,
    input  logic              cfg_ack_en,
    input  logic [LVL_W-1:0]  cfg_rx_thresh,
    input  logic              cfg_rx_ie,
    input  logic              host_pop,
    input  logic              host_int_clr,
    input  logic              host_cond_clr,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic [LVL_W-1:0]  rx_level_o,
    output logic              int_flag_o,
    output logic              reserved_o,
    output logic              stop_flag_o,
    output logic              rstart_flag_o,
    output logic              rx_ready_o,
    output logic              rx_irq_o
);

    logic              rise, fall, start, stop;
    logic              push, full;
    logic [BYTE_W-1:0] push_data;

    i2c_target_rx_cond u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .rise_o  (rise),
        .fall_o  (fall),
        .start_o (start),
        .stop_o  (stop)
    );

    i2c_target_rx_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl_i),
        .sda_i         (sda_i),
        .rise_i        (rise),
        .fall_i        (fall),
        .start_i       (start),
        .stop_i        (stop),
        .cfg_own_addr  (cfg_own_addr),
        .cfg_addr_mask (cfg_addr_mask),
        .cfg_fifo_en   (cfg_fifo_en),
        .cfg_wait_sel  (cfg_wait_sel),
        .cfg_ack_en    (cfg_ack_en),
        .fifo_full_i   (full),
        .host_int_clr  (host_int_clr),
        .host_cond_clr (host_cond_clr),
        .push_o        (push),
        .push_data_o   (push_data),
        .scl_pd_o      (scl_pd_o),
        .sda_pd_o      (sda_pd_o),
        .int_o         (int_flag_o),
        .reserved_o    (reserved_o),
        .stop_o        (stop_flag_o),
        .rstart_o      (rstart_flag_o)
    );

    i2c_target_rx_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (BYTE_W)
    ) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_data_i (push_data),
        .pop_i       (host_pop),
        .thresh_i    (cfg_rx_thresh),
        .head_o      (rx_data_o),
        .level_o     (rx_level_o),
        .full_o      (full),
        .ready_o     (rx_ready_o)
    );

    assign rx_irq_o = rx_ready_o & cfg_rx_ie;

endmodule

// File: tb/i2c_target_rx_tb_top.sv
module i2c_target_rx_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic m_scl_pd = 1'b0;
    logic m_sda_pd = 1'b0;
    logic scl_line, sda_line;
    logic scl_pd_o, sda_pd_o;
    logic [6:0] cfg_own_addr = 7'h52;
    logic [6:0] cfg_addr_mask = 7'h7F;
    logic cfg_fifo_en = 1'b0, cfg_wait_sel = 1'b0, cfg_ack_en = 1'b1;
    logic [4:0] cfg_rx_thresh = 5'd0;
    logic cfg_rx_ie = 1'b0;
    logic host_pop = 1'b0, host_int_clr = 1'b0, host_cond_clr = 1'b0;
    logic [7:0] rx_data_o;
    logic [4:0] rx_level_o;
    logic int_flag_o, reserved_o, stop_flag_o, rstart_flag_o, rx_ready_o, rx_irq_o;

    assign scl_line = !(m_scl_pd || scl_pd_o);
    assign sda_line = !(m_sda_pd || sda_pd_o);

    i2c_target_rx dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_pd_o(scl_pd_o), .sda_pd_o(sda_pd_o),
        .cfg_own_addr(cfg_own_addr), .cfg_addr_mask(cfg_addr_mask),
        .cfg_fifo_en(cfg_fifo_en), .cfg_wait_sel(cfg_wait_sel),
        .cfg_ack_en(cfg_ack_en), .cfg_rx_thresh(cfg_rx_thresh),
        .cfg_rx_ie(cfg_rx_ie), .host_pop(host_pop),
        .host_int_clr(host_int_clr), .host_cond_clr(host_cond_clr),
        .rx_data_o(rx_data_o), .rx_level_o(rx_level_o),
        .int_flag_o(int_flag_o), .reserved_o(reserved_o),
        .stop_flag_o(stop_flag_o), .rstart_flag_o(rstart_flag_o),
        .rx_ready_o(rx_ready_o), .rx_irq_o(rx_irq_o)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        int n = 0;
        while (!scl_line && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 3000) chk("BUS", "scl stuck low", 0, 1);
    endtask

    task automatic m_start();
        m_sda_pd = 1'b1; half();
        m_scl_pd = 1'b1; half();
    endtask

    task automatic m_stop();
        m_sda_pd = 1'b1; half();
        m_scl_pd = 1'b0; wait_scl_high(); half();
        m_sda_pd = 1'b0; half();
    endtask

    task automatic m_rstart();
        m_sda_pd = 1'b0; half();
        m_scl_pd = 1'b0; wait_scl_high(); half();
        m_sda_pd = 1'b1; half();
        m_scl_pd = 1'b1; half();
    endtask

    task automatic send8(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda_pd = !b[i]; half();
            m_scl_pd = 1'b0; wait_scl_high(); half();
            m_scl_pd = 1'b1; half();
        end
    endtask

    task automatic ack_clk(output logic a);
        m_sda_pd = 1'b0; half();
        m_scl_pd = 1'b0; wait_scl_high();
        a = sda_line; half();
        m_scl_pd = 1'b1; half();
    endtask

    task automatic clr_int();
        @(negedge clk) host_int_clr = 1'b1;
        @(negedge clk) host_int_clr = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic clr_cond();
        @(negedge clk) host_cond_clr = 1'b1;
        @(negedge clk) host_cond_clr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pop1();
        @(negedge clk) host_pop = 1'b1;
        @(negedge clk) host_pop = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic address(input logic [7:0] b);
        logic a;
        m_start();
        send8(b);
        ack_clk(a);
        chk("R2", "own address ack", a, 0);
        clr_int();
    endtask

    typedef struct packed {
        logic [7:0] first;
        logic [6:0] own;
        logic [6:0] mask;
        logic       ack;
        logic       rsv;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{8'hA4, 7'h52, 7'h7F, 1'b1, 1'b0},
        '{8'hA5, 7'h52, 7'h7F, 1'b0, 1'b0},
        '{8'hA6, 7'h52, 7'h7F, 1'b0, 1'b0},
        '{8'hA6, 7'h52, 7'h7E, 1'b1, 1'b0},
        '{8'h0E, 7'h52, 7'h7F, 1'b1, 1'b1},
        '{8'hF3, 7'h52, 7'h7F, 1'b1, 1'b1},
        '{8'h30, 7'h18, 7'h7F, 1'b1, 1'b0},
        '{8'h60, 7'h18, 7'h07, 1'b1, 1'b0},
        '{8'h5A, 7'h52, 7'h7F, 1'b0, 1'b0}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL WATCHDOG run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk("R1", "scl_pd", scl_pd_o, 0);
        chk("R1", "sda_pd", sda_pd_o, 0);
        chk("R1", "int", int_flag_o, 0);
        chk("R1", "flags", {reserved_o, stop_flag_o, rstart_flag_o, rx_ready_o, rx_irq_o}, 0);
        chk("R1", "level", rx_level_o, 0);

        // R2 R3 address table
        for (int v = 0; v < NV; v++) begin
            cfg_own_addr = VEC[v].own;
            cfg_addr_mask = VEC[v].mask;
            m_start();
            send8(VEC[v].first);
            ack_clk(a);
            chk(VEC[v].rsv ? "R3" : "R2", "first byte ack", a, VEC[v].ack ? 0 : 1);
            chk("R2", "address int", int_flag_o, VEC[v].ack);
            chk("R2", "address hold", scl_pd_o, VEC[v].ack);
            if (VEC[v].ack) begin
                chk("R3", "reserved", reserved_o, VEC[v].rsv);
                clr_int();
                chk("R12", "hold released", scl_pd_o, 0);
            end
            m_stop();
            chk("R3", "stop flag only when addressed", stop_flag_o, VEC[v].ack);
            clr_cond();
        end
        cfg_own_addr = 7'h52;
        cfg_addr_mask = 7'h7F;

        // R5 R7 queue off, stretch after bit 8
        address(8'hA4);
        send8(8'h3C);
        chk("R5", "hold after bit 8", scl_pd_o, 1);
        chk("R5", "int after bit 8", int_flag_o, 1);
        chk("R4", "level", rx_level_o, 1);
        chk("R4", "data", rx_data_o, 8'h3C);
        cfg_ack_en = 1'b0;
        clr_int();
        ack_clk(a);
        chk("R7", "nack taken at release", a, 1);
        chk("R5", "no hold after ack", scl_pd_o, 0);
        chk("R5", "no int after ack", int_flag_o, 0);
        cfg_ack_en = 1'b1;
        pop1();
        chk("R4", "level after pop", rx_level_o, 0);
        m_stop();
        chk("R10", "stop flag", stop_flag_o, 1);
        chk("R10", "stop no int", int_flag_o, 0);
        clr_cond();
        chk("R10", "cond clr", {stop_flag_o, rstart_flag_o}, 0);

        // R6 queue off, stretch after ack
        cfg_wait_sel = 1'b1;
        address(8'hA4);
        send8(8'h81);
        chk("R6", "no hold after bit 8", scl_pd_o, 0);
        chk("R6", "no int after bit 8", int_flag_o, 0);
        ack_clk(a);
        chk("R7", "ack", a, 0);
        chk("R6", "hold after ack", scl_pd_o, 1);
        chk("R6", "int after ack", int_flag_o, 1);
        chk("R4", "data", rx_data_o, 8'h81);
        pop1();
        clr_int();
        m_rstart();
        chk("R10", "rstart flag", rstart_flag_o, 1);
        chk("R10", "rstart no int", int_flag_o, 0);
        chk("R10", "rstart no hold", scl_pd_o, 0);
        send8(8'hA4);
        ack_clk(a);
        chk("R2", "ack after rstart", a, 0);
        clr_int();
        m_stop();
        clr_cond();

        // R8 R9 R11 R12 queue on
        cfg_fifo_en = 1'b1;
        cfg_rx_thresh = 5'd3;
        cfg_rx_ie = 1'b1;
        address(8'hA4);
        for (int k = 0; k < 16; k++) begin
            send8(8'h10 + 8'(k));
            ack_clk(a);
            chk("R8", "ack in queue mode", a, 0);
            if (k == 1) chk("R11", "not ready below thresh", rx_ready_o, 0);
            if (k == 2) begin
                chk("R11", "ready at thresh", rx_ready_o, 1);
                chk("R11", "rx irq", rx_irq_o, 1);
            end
            if (k < 15) begin
                chk("R8", "no hold with room", scl_pd_o, 0);
                chk("R8", "no int on ack", int_flag_o, 0);
            end
        end
        chk("R9", "full hold", scl_pd_o, 1);
        chk("R9", "full no int", int_flag_o, 0);
        chk("R4", "level full", rx_level_o, 16);
        chk("R4", "oldest first", rx_data_o, 8'h10);
        pop1();
        chk("R9", "single pop releases", scl_pd_o, 0);
        chk("R4", "level after pop", rx_level_o, 15);
        cfg_ack_en = 1'b0;
        send8(8'hEE);
        ack_clk(a);
        chk("R7", "nack", a, 1);
        chk("R8", "nack int", int_flag_o, 1);
        chk("R8", "nack hold", scl_pd_o, 1);
        cfg_ack_en = 1'b1;
        clr_int();
        chk("R12", "int cleared", int_flag_o, 0);
        chk("R12", "full hold continues", scl_pd_o, 1);
        pop1();
        chk("R9", "released by pop", scl_pd_o, 0);
        m_stop();
        chk("R10", "stop flag", stop_flag_o, 1);
        clr_cond();
        for (int k = 0; k < 15; k++) begin
            chk("R4", "drain order", rx_data_o, (k < 14) ? 8'h12 + k : 8'hEE);
            pop1();
        end
        chk("R4", "drained", rx_level_o, 0);
        chk("R11", "ready cleared below thresh", rx_ready_o, 0);

        // R11 enable gating and zero threshold
        cfg_rx_thresh = 5'd1;
        cfg_rx_ie = 1'b0;
        address(8'hA4);
        send8(8'h5D);
        ack_clk(a);
        chk("R11", "ready at 1", rx_ready_o, 1);
        chk("R11", "irq gated", rx_irq_o, 0);
        cfg_rx_thresh = 5'd0;
        repeat (2) @(negedge clk);
        send8(8'h6E);
        ack_clk(a);
        chk("R11", "threshold 0 never ready", rx_ready_o, 0);
        m_stop();
        clr_cond();
        chk("R4", "data", rx_data_o, 8'h5D);
        pop1();
        chk("R4", "data", rx_data_o, 8'h6E);
        pop1();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule